// File: doc/BRIEF.md
# SAR Converter Serial Output Sequencer

This block is the digital controller of a successive-approximation converter that has a three-wire serial output. A falling active-low select starts a cycle. The block first holds off for a sampling window. It then settles one result bit per clock: it places a trial code on `dac_code_o`, reads a one-bit comparator decision on the following rising clock edge, and shifts that bit out on `dout_o` at the next falling edge. Because each bit leaves as soon as it is decided, the serial stream belongs to the conversion in progress and has no pipeline delay.

The serial word has a fixed order. A forced low lead bit comes first, then the result from the most significant bit down. The word is then replayed from bit 1 up to the top bit. After the replay the output either floats or, when `TAIL_ZERO` is set, drives zeros for as long as the select stays low. Raising the select at any point cuts the cycle short, floats the output and flags full power-down. The analog DAC, the comparator and the sample/hold are modelled outside the block.

Top module: `sar_serial_seq`

## Requirements
- R1: While reset is held and while `cs_ni` is high, `dout_oe_o` is 0, `ana_pd_o` and `dig_pd_o` are 1 and `dac_code_o` is 0.
- R2: Falling clock edges are counted from the fall of `cs_ni`. During the first `SAMPLE_CLKS` (default 2) counted falls, `dout_oe_o` stays 0. After the first fall, `dac_code_o` is still 0.
- R3: At fall `SAMPLE_CLKS` the output is enabled and drives a low lead bit for one clock.
- R4: At falls `SAMPLE_CLKS+1` to `SAMPLE_CLKS+DATA_W` (3 to 14 by default), `dout_o` carries the result from bit `DATA_W-1` down to bit 0. The comparator input reads 1 when the analog input is at or above the trial code, and a 1 keeps the trial bit.
- R5: The bit shown after a fall is the comparator decision taken at the rising edge just before that fall, within the current conversion. A new conversion never shows bits from the previous one.
- R6: At falls `SAMPLE_CLKS+DATA_W+1` to `SAMPLE_CLKS+2*DATA_W-1` (15 to 25), `dout_o` replays the result from bit 1 up to bit `DATA_W-1`.
- R7: From fall `SAMPLE_CLKS+2*DATA_W` (26) on, with `cs_ni` still low, `dout_oe_o` is 0 when `TAIL_ZERO`=0. When `TAIL_ZERO`=1, the output stays enabled and drives 0.
- R8: Raising `cs_ni` at any fall count drives `dout_oe_o` to 0 and sets both power-down flags without waiting for a clock. The next low period of `cs_ni` starts a fresh conversion.
- R9: Once the last bit is decided, further clocks with `cs_ni` low leave `dac_code_o` at the final result and leave the result unchanged.
- R10: The result is straight binary. An input of 0 gives code 000h, half scale gives 800h, one step below half gives 7FFh and full scale gives FFFh.
- R11: `dig_pd_o` equals the select level. `ana_pd_o` is 0 from the fall of `cs_ni` until fall `SAMPLE_CLKS+DATA_W` and is 1 from then on.
- R12: While bit i is being decided, `dac_code_o` holds the bits already decided, bit i set to 1, and all lower bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock: bits decided on rising edges, shifted on falling edges |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low select; high means abort and full power-down |
| comp_i | input | 1 | Comparator decision, 1 when input is at or above the trial code |
| dac_code_o | output | DATA_W | Trial code for the external DAC |
| dout_o | output | 1 | Serial data, high impedance when disabled |
| dout_oe_o | output | 1 | Serial output enable |
| ana_pd_o | output | 1 | Analog section power-down flag |
| dig_pd_o | output | 1 | Digital section power-down flag |

## Verification
The bench aims at the boundaries of the serial frame. If the lead bit were dropped or doubled, every data bit would shift by one fall and the MSB-first checks would fail. If the replay started at bit 0 instead of bit 1, or ran one bit too far, the tail checks would fail. Extreme codes (000h, FFFh, 800h, 7FFh, 001h) catch a comparator polarity error or a trial bit left set. The trial code is checked at every decision step, which exposes a wrong keep or clear rule. A conversion is cut short and then restarted with a different input. A sequencer that failed to clear on the select rising would leak old bits into the new word or keep the output enabled. Two instances, one per tail option, confirm that the output floats in one case and drives zeros in the other.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
   // Position of the serial frame as decoded from the fall count.
   typedef enum logic [2:0] {
      PH_SAMPLE = 3'd0,
      PH_LEAD   = 3'd1,
      PH_DOWN   = 3'd2,
      PH_UP     = 3'd3,
      PH_TAIL   = 3'd4
   } phase_e;
endpackage

// File: rtl/sarseq_step.sv
// Falling-edge fall counter and frame decoder.
module sarseq_step
   import sarseq_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int SAMPLE_CLKS = 2,
   localparam int LAST       = SAMPLE_CLKS + 2 * DATA_W,
   localparam int STEP_W     = $clog2(LAST + 1),
   localparam int IDX_W      = $clog2(DATA_W)
) (
   input  logic             clk_i,
   input  logic             clr_i,
   output phase_e           phase_o,
   output logic [IDX_W-1:0] show_idx_o,
   output logic             dec_vld_o,
   output logic [IDX_W-1:0] dec_idx_o,
   output logic             done_o
);
   logic [STEP_W-1:0] step_q;

   always_ff @(negedge clk_i or posedge clr_i) begin
      if (clr_i)
         step_q <= '0;
      else if (int'(step_q) != LAST)
         step_q <= step_q + 1'b1;
   end

   always_comb begin
      int s;
      s          = int'(step_q);
      phase_o    = PH_SAMPLE;
      show_idx_o = '0;
      if (s < SAMPLE_CLKS) begin
         phase_o = PH_SAMPLE;
      end else if (s == SAMPLE_CLKS) begin
         phase_o = PH_LEAD;
      end else if (s <= SAMPLE_CLKS + DATA_W) begin
         phase_o    = PH_DOWN;
         show_idx_o = IDX_W'(SAMPLE_CLKS + DATA_W - s);
      end else if (s < LAST) begin
         phase_o    = PH_UP;
         show_idx_o = IDX_W'(s - SAMPLE_CLKS - DATA_W);
      end else begin
         phase_o = PH_TAIL;
      end
      dec_vld_o = (s >= SAMPLE_CLKS) && (s <= SAMPLE_CLKS + DATA_W - 1);
      dec_idx_o = dec_vld_o ? IDX_W'(SAMPLE_CLKS + DATA_W - 1 - s) : '0;
      done_o    = (s >= SAMPLE_CLKS + DATA_W);
   end
endmodule

// File: rtl/sarseq_approx.sv
// Successive-approximation register: rising-edge keep/clear of the trial bit.
module sarseq_approx #(
   parameter int DATA_W = 12,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk_i,
   input  logic              clr_i,
   input  logic              dec_vld_i,
   input  logic [IDX_W-1:0]  dec_idx_i,
   input  logic              comp_i,
   output logic [DATA_W-1:0] result_o,
   output logic [DATA_W-1:0] dac_code_o
);
   logic [DATA_W-1:0] res_q;
   logic [DATA_W-1:0] trial_bit;

   assign trial_bit = dec_vld_i ? (DATA_W'(1) << dec_idx_i) : '0;

   always_ff @(posedge clk_i or posedge clr_i) begin
      if (clr_i)
         res_q <= '0;
      else if (dec_vld_i && comp_i)
         res_q <= res_q | trial_bit;
   end

   assign result_o   = res_q;
   assign dac_code_o = res_q | trial_bit;
endmodule

// File: rtl/sarseq_txmux.sv
// Serial bit and enable select; tail behaviour chosen at elaboration.
module sarseq_txmux
   import sarseq_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int TAIL_ZERO = 0,
   localparam int IDX_W    = $clog2(DATA_W)
) (
   input  phase_e            phase_i,
   input  logic [IDX_W-1:0]  show_idx_i,
   input  logic [DATA_W-1:0] result_i,
   output logic              bit_o,
   output logic              oe_o
);
   logic tail_oe;

   if (TAIL_ZERO != 0) begin : g_tail_zero
      assign tail_oe = 1'b1;
   end else begin : g_tail_float
      assign tail_oe = 1'b0;
   end

   always_comb begin
      bit_o = 1'b0;
      oe_o  = 1'b0;
      unique case (phase_i)
         PH_SAMPLE: oe_o = 1'b0;
         PH_LEAD:   oe_o = 1'b1;
         PH_DOWN, PH_UP: begin
            oe_o  = 1'b1;
            bit_o = result_i[show_idx_i];
         end
         PH_TAIL:   oe_o = tail_oe;
         default:   oe_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
   import sarseq_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int SAMPLE_CLKS = 2,
   parameter int TAIL_ZERO   = 0,
   localparam int IDX_W      = $clog2(DATA_W)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cs_ni,
   input  logic              comp_i,
   output logic [DATA_W-1:0] dac_code_o,
   output wire               dout_o,
   output logic              dout_oe_o,
   output logic              ana_pd_o,
   output logic              dig_pd_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("sar_serial_seq: DATA_W must be at least 2");
   end
   if (SAMPLE_CLKS < 1) begin : g_bad_sample
      $error("sar_serial_seq: SAMPLE_CLKS must be at least 1");
   end
   if (TAIL_ZERO != 0 && TAIL_ZERO != 1) begin : g_bad_tail
      $error("sar_serial_seq: TAIL_ZERO must be 0 or 1");
   end

   logic              clr;
   phase_e            phase;
   logic [IDX_W-1:0]  show_idx;
   logic              dec_vld;
   logic [IDX_W-1:0]  dec_idx;
   logic              done;
   logic [DATA_W-1:0] result;
   logic              tx_bit;
   logic              tx_oe;

   // Select high or reset clears the whole cycle without waiting for a clock.
   assign clr = ~rst_ni | cs_ni;

   sarseq_step #(.DATA_W(DATA_W), .SAMPLE_CLKS(SAMPLE_CLKS)) step_i (
      .clk_i      (clk_i),
      .clr_i      (clr),
      .phase_o    (phase),
      .show_idx_o (show_idx),
      .dec_vld_o  (dec_vld),
      .dec_idx_o  (dec_idx),
      .done_o     (done)
   );

   sarseq_approx #(.DATA_W(DATA_W)) approx_i (
      .clk_i      (clk_i),
      .clr_i      (clr),
      .dec_vld_i  (dec_vld),
      .dec_idx_i  (dec_idx),
      .comp_i     (comp_i),
      .result_o   (result),
      .dac_code_o (dac_code_o)
   );

   sarseq_txmux #(.DATA_W(DATA_W), .TAIL_ZERO(TAIL_ZERO)) txmux_i (
      .phase_i    (phase),
      .show_idx_i (show_idx),
      .result_i   (result),
      .bit_o      (tx_bit),
      .oe_o       (tx_oe)
   );

   assign dout_oe_o = tx_oe;
   assign dout_o    = tx_oe ? tx_bit : 1'bz;
   assign ana_pd_o  = clr | done;
   assign dig_pd_o  = clr;
endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk
   import sarseq_pkg::*;
#(
   parameter int TAIL_ZERO = 0
) (
   input logic   clk_i,
   input logic   rst_ni,
   input logic   cs_ni,
   input logic   comp_i,
   input logic   dout_oe_o,
   input logic   tx_bit_i,
   input phase_e phase_i,
   input logic   ana_pd_o,
   input logic   dig_pd_o
);
   logic comp_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) comp_q <= 1'b0;
      else         comp_q <= comp_i;
   end

   p_sample_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
      (phase_i == PH_SAMPLE) |-> !dout_oe_o);

   p_lead_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
      $rose(dout_oe_o) |-> (phase_i == PH_LEAD && !tx_bit_i));

   // R5: bit on the wire is the decision of the preceding rising edge.
   p_no_pipe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
      (phase_i == PH_DOWN) |-> (tx_bit_i == comp_q));

   if (TAIL_ZERO != 0) begin : g_chk_zero
      p_tail_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
         (phase_i == PH_TAIL) |=> (dout_oe_o && !tx_bit_i));
   end else begin : g_chk_float
      p_tail_float_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
         (phase_i == PH_TAIL) |=> (!dout_oe_o && phase_i == PH_TAIL));
   end

   p_deselect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_ni |-> (!dout_oe_o && ana_pd_o && dig_pd_o));

   p_analog_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
      ((phase_i == PH_SAMPLE || phase_i == PH_LEAD) |-> !ana_pd_o) and
      ((phase_i == PH_UP) |-> ana_pd_o));
endmodule

bind sar_serial_seq sar_serial_seq_chk #(.TAIL_ZERO(TAIL_ZERO)) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .cs_ni     (cs_ni),
   .comp_i    (comp_i),
   .dout_oe_o (dout_oe_o),
   .tx_bit_i  (tx_bit),
   .phase_i   (phase),
   .ana_pd_o  (ana_pd_o),
   .dig_pd_o  (dig_pd_o)
);

// File: tb/sar_serial_seq_tb_top.sv
module sar_serial_seq_tb_top;
   localparam int N  = 12;
   localparam int SC = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1;
   int           vin = 0;
   logic [N-1:0] dac_a, dac_b;
   wire          dout_a, dout_b;
   logic         oe_a, oe_b, apd_a, apd_b, dpd_a, dpd_b;
   logic         comp_a, comp_b;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   // Behavioural comparator: input at or above trial code gives 1.
   assign comp_a = (vin >= int'(dac_a));
   assign comp_b = (vin >= int'(dac_b));

   sar_serial_seq #(.DATA_W(N), .SAMPLE_CLKS(SC), .TAIL_ZERO(0)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .comp_i(comp_a),
      .dac_code_o(dac_a), .dout_o(dout_a), .dout_oe_o(oe_a),
      .ana_pd_o(apd_a), .dig_pd_o(dpd_a));

   sar_serial_seq #(.DATA_W(N), .SAMPLE_CLKS(SC), .TAIL_ZERO(1)) dut_zero_i (
      .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .comp_i(comp_b),
      .dac_code_o(dac_b), .dout_o(dout_b), .dout_oe_o(oe_b),
      .ana_pd_o(apd_b), .dig_pd_o(dpd_b));

   typedef struct {
      int           k;
      logic         oe_a;
      logic         oe_b;
      logic         d;
      logic         apd;
      bit           chk_dac;
      logic [N-1:0] dac;
      string        tag;
      string        dac_tag;
   } exp_t;

   exp_t q[$];

   task automatic check(string tag, string what, int act, int expv);
      n_chk++;
      if (act != expv) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   function automatic exp_t mk(int k, int v, string dtag);
      exp_t e;
      int   hi;
      e.k = k; e.oe_a = 1'b1; e.oe_b = 1'b1; e.d = 1'b0;
      e.apd = (k >= SC + N); e.chk_dac = 1'b0; e.dac = '0;
      e.tag = dtag; e.dac_tag = "R12";
      if (k < SC) begin
         e.oe_a = 1'b0; e.oe_b = 1'b0; e.tag = "R2";
         if (k == 1) begin e.chk_dac = 1'b1; e.dac = '0; e.dac_tag = "R2"; end
      end else if (k == SC) begin
         e.tag = "R3"; e.chk_dac = 1'b1; e.dac = N'(1) << (N - 1);
      end else if (k <= SC + N) begin
         e.d = v[SC + N - k];
         e.chk_dac = 1'b1;
         if (k < SC + N) begin
            hi = SC + N - k;  // bits at and above hi are decided
            e.dac = (N'(v) & (N'('1) << hi)) | (N'(1) << (hi - 1));
         end else begin
            e.dac = N'(v);
         end
      end else if (k < SC + 2 * N) begin
         e.d = v[k - SC - N]; e.tag = "R6";
      end else begin
         e.oe_a = 1'b0; e.oe_b = 1'b1; e.d = 1'b0; e.tag = "R7";
         e.chk_dac = 1'b1; e.dac = N'(v); e.dac_tag = "R9";
      end
      return e;
   endfunction

   // Monitor: one expected item per falling edge, compared shortly after it.
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #2;
         if (q.size() > 0) begin
            e = q.pop_front();
            check(e.tag, $sformatf("oe fall %0d", e.k), int'(oe_a), int'(e.oe_a));
            check(e.k >= SC + 2 * N ? "R7" : e.tag, $sformatf("oe(zero tail) fall %0d", e.k),
                  int'(oe_b), int'(e.oe_b));
            if (e.oe_a) check(e.tag, $sformatf("dout fall %0d", e.k), int'(dout_a), int'(e.d));
            if (e.oe_b) check(e.tag, $sformatf("dout(zero tail) fall %0d", e.k), int'(dout_b), int'(e.d));
            check("R11", $sformatf("ana_pd fall %0d", e.k), int'(apd_a), int'(e.apd));
            check("R11", $sformatf("dig_pd fall %0d", e.k), int'(dpd_a), 0);
            if (e.chk_dac)
               check(e.dac_tag, $sformatf("dac_code fall %0d", e.k), int'(dac_a), int'(e.dac));
         end
      end
   end

   // Driver: select low, push expected frame, then deselect and check idle.
   task automatic run_conv(int v, int nf, string dtag);
      @(posedge clk); #1;
      vin  = v;
      cs_n = 1'b0;
      for (int k = 1; k <= nf; k++) begin
         q.push_back(mk(k, v, dtag));
         @(negedge clk);
      end
      @(posedge clk); #1;
      cs_n = 1'b1;
      #1;
      check("R8", "oe after deselect", int'(oe_a), 0);
      check("R8", "oe(zero tail) after deselect", int'(oe_b), 0);
      check("R8", "ana_pd after deselect", int'(apd_a), 1);
      check("R8", "dig_pd after deselect", int'(dpd_a), 1);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1", "oe in reset", int'(oe_a), 0);
      check("R1", "dig_pd in reset", int'(dpd_a), 1);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1", "oe idle", int'(oe_a), 0);
      check("R1", "ana_pd idle", int'(apd_a), 1);
      check("R1", "dig_pd idle", int'(dpd_a), 1);
      check("R1", "dac_code idle", int'(dac_a), 0);

      run_conv(12'h5A3, 30, "R4");   // full frame, tail, extra clocks (R9)
      run_conv(12'h000, 26, "R10");
      run_conv(12'hFFF, 26, "R10");
      run_conv(12'h800, 26, "R10");
      run_conv(12'h7FF, 26, "R10");
      run_conv(12'h001, 27, "R10");
      run_conv(12'h9C4, 8, "R4");    // short cycle, R8
      run_conv(12'h3B1, 26, "R5");   // fresh bits right after an abort
      run_conv(12'hA5C, SC + 1, "R4"); // abort right after first data bit
      run_conv(12'h2E7, 28, "R5");

      repeat (2) @(posedge clk);
      summary();
      $finish;
   end
endmodule